// File: doc/BRIEF.md
# Re-arbitration Point Detector for a Shared Slave Port

This block observes the transfer controls that masters present to one shared slave port of an on-chip bus crossbar. On every cycle it raises `rearb_ok` if the slave's arbiter may hand the port to another master in that cycle. The arbiter uses this strobe to decide when to run its grant selection. The block does not choose a master and carries no data.

A switch is allowed in five cases:
- when the port sees an idle transfer;
- when a single (non-burst) transfer is accepted;
- on the final beat of a fixed-length burst;
- at a predicted end inside an undefined-length incrementing burst. The break spacing is 4, 8 or 16 beats, or no break at all. The setting comes from the configuration of the master that holds the grant.
- when a per-slave slot-cycle timer has run out and a beat completes.

The design centres on a small state machine with three states:
- `ST_IDLE`: no burst is in progress.
- `ST_FIXED`: a fixed-length burst is in progress.
- `ST_UNDEF`: an undefined-length incrementing burst is in progress.

Its transitions are:
- `start_fixed`: a burst NONSEQ of a fixed-length burst is accepted. It moves to `ST_FIXED` from any state.
- `start_undef`: a burst NONSEQ of kind INCR is accepted. It moves to `ST_UNDEF` from any state.
- `single_done`: an accepted NONSEQ single moves the machine to `ST_IDLE`.
- `fixed_last`: the final SEQ beat of a fixed-length burst moves `ST_FIXED` to `ST_IDLE`.
- `abandon`: an accepted idle transfer moves any burst state to `ST_IDLE`.
- `beat`: any other accepted SEQ beat keeps the current state and advances the beat index.

Top module: `rearb_point_detect`

## Requirements
- R1: When `xfer_type` is 2'b00 (idle) and `xfer_ready` is 1, `rearb_ok` is 1 in the same cycle.
- R2: When `xfer_type` is 2'b10 (NONSEQ), `burst_kind` is 3'b000 (single) and `xfer_ready` is 1, `rearb_ok` is 1 in the same cycle.
- R3: A NONSEQ beat with `burst_kind` 3'b010 or 3'b011 starts a 4-beat burst. With 3'b100 or 3'b101 the burst has 8 beats, and with 3'b110 or 3'b111 it has 16. The NONSEQ beat is beat 1. `rearb_ok` is 1 on the accepted SEQ beat that is the last beat of the burst, and the machine then returns to no-burst.
- R4: A NONSEQ beat with `burst_kind` 3'b001 (INCR) captures `incr_break_sel`. The value 2'b00 never predicts an end. The values 2'b01, 2'b10 and 2'b11 raise `rearb_ok` on every accepted SEQ beat whose beat number is a multiple of 4, 8 and 16 respectively.
- R5: Changes to `incr_break_sel` after the NONSEQ beat of an INCR burst have no effect on that burst.
- R6: An accepted burst NONSEQ loads the slot counter with `slot_limit`. The counter then decrements on every clock while a burst is active. When it is zero, the next accepted SEQ beat raises `rearb_ok`. Every SEQ beat that raises `rearb_ok` reloads the counter from `slot_limit`.
- R7: A `slot_limit` of 0 at load disables the timeout. The counter holds at zero and never wraps.
- R8: `rearb_ok` is 0 in three situations: when `xfer_ready` is 0; on BUSY (2'b01); and on a burst beat with none of the causes above.
- R9: After reset the block is in the no-burst state, so a SEQ beat (2'b11) without a preceding NONSEQ gives `rearb_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_type | input | 2 | Transfer type: 00 idle, 01 busy, 10 NONSEQ, 11 SEQ |
| burst_kind | input | 3 | Burst type: 000 single, 001 INCR, 01x 4-beat, 10x 8-beat, 11x 16-beat |
| xfer_ready | input | 1 | Slave ready; a beat completes when high |
| incr_break_sel | input | 2 | Granted master's INCR break spacing: 00 none, 01 4, 10 8, 11 16 beats |
| slot_limit | input | SLOT_W | Slave slot-cycle limit; 0 disables the timeout |
| rearb_ok | output | 1 | Re-arbitration permitted in this cycle |

## Verification
The slot timeout can expire on the same beat as a burst end. The burst end can be the last beat of a fixed burst or a predicted INCR boundary. In that cycle both causes must produce one strobe and one reload, and a fixed burst must still close. Directed bursts provoke this by choosing `slot_limit` as the beat distance minus one: 14 for a 16-beat burst and 2 for INCR with 4-beat spacing. Long random runs with small limits and wait states then hit further overlaps. A bench model derived from the requirements computes the expected strobe for every cycle.

// File: rtl/rap_pkg.sv
package rap_pkg;

    localparam int BEAT_W = 4;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    typedef enum logic [1:0] {
        BRK_NONE = 2'b00,
        BRK_4    = 2'b01,
        BRK_8    = 2'b10,
        BRK_16   = 2'b11
    } brk_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_FIXED = 2'b01,
        ST_UNDEF = 2'b10
    } bst_e;

    typedef struct packed {
        logic       idle_acc;
        logic       busy;
        logic       ns_acc;
        logic       sq_acc;
        logic       single;
        logic       undef;
        logic [1:0] len_sel;
    } xfer_t;

    function automatic logic [BEAT_W-1:0] last_index(input logic [1:0] len_sel);
        logic [BEAT_W-1:0] r;
        unique case (len_sel)
            2'b01:   r = BEAT_W'(3);
            2'b10:   r = BEAT_W'(7);
            default: r = BEAT_W'(15);
        endcase
        return r;
    endfunction

    function automatic logic [BEAT_W-1:0] break_mask(input logic [1:0] sel);
        return BEAT_W'((1 << (int'(sel) + 1)) - 1);
    endfunction

endpackage

// File: rtl/rap_xfer_decode.sv
module rap_xfer_decode
    import rap_pkg::*;
(
    input  logic [1:0] xfer_type,
    input  logic [2:0] burst_kind,
    input  logic       xfer_ready,
    output xfer_t      xf
);
    always_comb begin
        xf          = '0;
        xf.idle_acc = (xfer_type == TR_IDLE) && xfer_ready;
        xf.busy     = (xfer_type == TR_BUSY);
        xf.ns_acc   = (xfer_type == TR_NSEQ) && xfer_ready;
        xf.sq_acc   = (xfer_type == TR_SEQ) && xfer_ready;
        xf.single   = (burst_kind == 3'b000);
        xf.undef    = (burst_kind == 3'b001);
        xf.len_sel  = burst_kind[2:1];
    end
endmodule

// File: rtl/rap_burst_fsm.sv
module rap_burst_fsm
    import rap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  xfer_t      xf,
    input  logic [1:0] brk_sel,
    output logic       end_pt,
    output logic       in_burst,
    output logic       burst_start
);
    bst_e              state_q, state_d;
    logic [BEAT_W-1:0] idx_q, idx_d;
    logic [1:0]        len_q, len_d;
    logic [1:0]        brk_q, brk_d;
    logic              fixed_last, undef_brk;

    assign fixed_last = (idx_q == last_index(len_q));
    assign undef_brk  = (brk_q != BRK_NONE) &&
                        ((idx_q & break_mask(brk_q)) == break_mask(brk_q));

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        len_d   = len_q;
        brk_d   = brk_q;
        if (xf.ns_acc) begin
            if (xf.single) begin
                state_d = ST_IDLE;                  // single_done
            end else begin
                state_d = xf.undef ? ST_UNDEF : ST_FIXED;  // start_undef / start_fixed
                idx_d   = BEAT_W'(1);
                len_d   = xf.len_sel;
                brk_d   = brk_sel;
            end
        end else if (xf.sq_acc) begin
            unique case (state_q)
                ST_IDLE:  ;
                ST_FIXED: begin
                    idx_d = idx_q + 1'b1;
                    if (fixed_last) state_d = ST_IDLE;  // fixed_last
                end
                ST_UNDEF: idx_d = idx_q + 1'b1;         // beat
                default:  state_d = ST_IDLE;
            endcase
        end else if (xf.idle_acc) begin
            state_d = ST_IDLE;                          // abandon
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            len_q   <= 2'b11;
            brk_q   <= BRK_NONE;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            len_q   <= len_d;
            brk_q   <= brk_d;
        end
    end

    always_comb begin
        end_pt      = 1'b0;
        in_burst    = (state_q != ST_IDLE);
        burst_start = xf.ns_acc && !xf.single;
        unique case (state_q)
            ST_FIXED: end_pt = xf.sq_acc && fixed_last;
            ST_UNDEF: end_pt = xf.sq_acc && undef_brk;
            default:  end_pt = 1'b0;
        endcase
    end

    // R3: the beat index never runs past the last beat of a fixed burst
    a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIXED) |-> (idx_q <= last_index(len_q)));

    // R5: captured break spacing stays frozen during an INCR burst
    a_r5_brk_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNDEF && !xf.ns_acc) |=> $stable(brk_q));

    // R3: the final fixed beat closes the burst
    a_r3_close: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIXED && xf.sq_acc && fixed_last) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/rap_slot_timer.sv
module rap_slot_timer #(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [SLOT_W-1:0] limit,
    output logic              slot_hit
);
    logic [SLOT_W-1:0] cnt_q;
    logic              en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (load) begin
            cnt_q <= limit;
            en_q  <= (limit != '0);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign slot_hit = en_q && (cnt_q == '0);

    // R7: counter never wraps away from zero on its own
    a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

    // R6: one step down per clock while a burst runs
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rearb_point_detect.sv
module rearb_point_detect
    import rap_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        xfer_type,
    input  logic [2:0]        burst_kind,
    input  logic              xfer_ready,
    input  logic [1:0]        incr_break_sel,
    input  logic [SLOT_W-1:0] slot_limit,
    output logic              rearb_ok
);
    xfer_t xf;
    logic  end_pt, in_burst, burst_start, slot_hit, seq_pt, slot_load;

    rap_xfer_decode u_dec (
        .xfer_type  (xfer_type),
        .burst_kind (burst_kind),
        .xfer_ready (xfer_ready),
        .xf         (xf)
    );

    rap_burst_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .xf          (xf),
        .brk_sel     (incr_break_sel),
        .end_pt      (end_pt),
        .in_burst    (in_burst),
        .burst_start (burst_start)
    );

    assign seq_pt    = xf.sq_acc && in_burst && (end_pt || slot_hit);
    assign slot_load = burst_start || seq_pt;

    rap_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (slot_load),
        .run      (in_burst),
        .limit    (slot_limit),
        .slot_hit (slot_hit)
    );

    assign rearb_ok = xf.idle_acc || (xf.ns_acc && xf.single) || seq_pt;

    // R1: accepted idle always allows a switch
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_type == 2'b00 && xfer_ready) |-> rearb_ok);

    // R2: accepted single always allows a switch
    a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_type == 2'b10 && burst_kind == 3'b000 && xfer_ready) |-> rearb_ok);

    // R8: no switch during wait states or busy cycles
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_ready || xfer_type == 2'b01) |-> !rearb_ok);

    // R9: SEQ outside a burst never allows a switch
    a_r9_stray_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_burst && xfer_type == 2'b11) |-> !rearb_ok);
endmodule

// File: tb/rearb_point_detect_tb.sv
module rearb_point_detect_tb;
    localparam int SLOT_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        xfer_type = 2'b00;
    logic [2:0]        burst_kind = 3'b000;
    logic              xfer_ready = 1'b1;
    logic [1:0]        incr_break_sel = 2'b00;
    logic [SLOT_W-1:0] slot_limit = '0;
    logic              rearb_ok;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int m_st = 0;      // 0 none, 1 fixed, 2 incr
    int m_idx = 0;
    int m_len = 16;
    int m_brk = 0;
    int m_slot = 0;
    bit m_slot_en = 0;

    always #2 clk = ~clk;

    rearb_point_detect #(.SLOT_W(SLOT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_type(xfer_type), .burst_kind(burst_kind),
        .xfer_ready(xfer_ready), .incr_break_sel(incr_break_sel),
        .slot_limit(slot_limit), .rearb_ok(rearb_ok)
    );

    function automatic int len_of(input logic [2:0] bk);
        return (bk[2:1] == 2'b01) ? 4 : (bk[2:1] == 2'b10) ? 8 : 16;
    endfunction

    function automatic bit m_slot_hit();
        return m_slot_en && (m_slot == 0);
    endfunction

    function automatic bit m_out();
        int n;
        if (!xfer_ready) return 0;
        if (xfer_type == 2'b00) return 1;
        if (xfer_type == 2'b01) return 0;
        if (xfer_type == 2'b10) return burst_kind == 3'b000;
        if (m_st == 1) return (m_idx == m_len - 1) || m_slot_hit();
        if (m_st == 2) begin
            n = (m_brk == 1) ? 4 : (m_brk == 2) ? 8 : 16;
            return (m_brk != 0 && ((m_idx + 1) % n) == 0) || m_slot_hit();
        end
        return 0;
    endfunction

    task automatic m_update(input bit strobe);
        if (xfer_ready && xfer_type == 2'b10) begin
            if (burst_kind == 3'b000) m_st = 0;
            else begin
                m_st = (burst_kind == 3'b001) ? 2 : 1;
                m_len = len_of(burst_kind);
                m_idx = 1;
                m_brk = int'(incr_break_sel);
                m_slot = int'(slot_limit);
                m_slot_en = (slot_limit != 0);
            end
        end else if (xfer_ready && xfer_type == 2'b11 && m_st != 0) begin
            if (strobe) begin
                m_slot = int'(slot_limit);
                m_slot_en = (slot_limit != 0);
                if (m_st == 1 && m_idx == m_len - 1) m_st = 0;
            end else if (m_slot != 0) m_slot--;
            m_idx = (m_idx + 1) % 16;
        end else begin
            if (m_st != 0 && m_slot != 0) m_slot--;
            if (xfer_ready && xfer_type == 2'b00) m_st = 0;
        end
    endtask

    task automatic step(input logic [1:0] tr, input logic [2:0] bk, input logic rdy,
                        input logic [1:0] brk, input int lim, input string tag);
        bit exp;
        @(negedge clk);
        xfer_type = tr; burst_kind = bk; xfer_ready = rdy;
        incr_break_sel = brk; slot_limit = SLOT_W'(lim);
        #1;
        exp = m_out();
        n_chk++;
        if (rearb_ok !== exp) begin
            n_fail++;
            $display("FAIL %s: rearb_ok=%0b expected %0b (type=%0d kind=%0d rdy=%0b t=%0t)",
                     tag, rearb_ok, exp, tr, bk, rdy, $time);
        end
        @(posedge clk);
        m_update(exp);
    endtask

    task automatic burst(input logic [2:0] bk, input int beats, input logic [1:0] brk,
                         input int lim, input string tag);
        step(2'b10, bk, 1'b1, brk, lim, tag);
        for (int i = 1; i < beats; i++) step(2'b11, bk, 1'b1, brk, lim, tag);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9: stray SEQ after reset
        step(2'b11, 3'b011, 1'b1, 2'b00, 0, "R9");
        // R1 idle, R8 idle in wait state
        step(2'b00, 3'b000, 1'b1, 2'b00, 0, "R1");
        step(2'b00, 3'b000, 1'b0, 2'b00, 0, "R8");
        // R2 single, also under wait
        step(2'b10, 3'b000, 1'b1, 2'b00, 0, "R2");
        step(2'b10, 3'b000, 1'b0, 2'b00, 0, "R8");
        // R3 fixed bursts of each length, wrap and incr forms
        burst(3'b011, 4, 2'b00, 0, "R3");
        burst(3'b100, 8, 2'b00, 0, "R3");
        burst(3'b111, 16, 2'b00, 0, "R3");
        // R8 busy and wait inside a burst
        step(2'b10, 3'b010, 1'b1, 2'b00, 0, "R8");
        step(2'b01, 3'b010, 1'b1, 2'b00, 0, "R8");
        step(2'b11, 3'b010, 1'b0, 2'b00, 0, "R8");
        step(2'b11, 3'b010, 1'b1, 2'b00, 0, "R8");
        step(2'b11, 3'b010, 1'b1, 2'b00, 0, "R8");
        step(2'b11, 3'b010, 1'b1, 2'b00, 0, "R3");
        // R4 each break spacing over 33 beats
        for (int s = 0; s < 4; s++) burst(3'b001, 33, 2'(s), 0, "R4");
        // R5 spacing changed mid-burst is ignored
        step(2'b10, 3'b001, 1'b1, 2'b01, 0, "R5");
        for (int i = 1; i < 20; i++) step(2'b11, 3'b001, 1'b1, 2'b00, 0, "R5");
        // R6 timeout with wait states on a long fixed burst
        step(2'b10, 3'b110, 1'b1, 2'b00, 3, "R6");
        for (int i = 1; i < 16; i++) begin
            step(2'b11, 3'b110, 1'b0, 2'b00, 3, "R6");
            step(2'b11, 3'b110, 1'b1, 2'b00, 3, "R6");
        end
        // R6 coincidence: timeout on the last fixed beat and on an INCR boundary
        burst(3'b111, 16, 2'b00, 14, "R6");
        burst(3'b001, 12, 2'b01, 2, "R6");
        // R7 zero limit disables timeout over a long unbroken INCR
        step(2'b10, 3'b001, 1'b1, 2'b00, 0, "R7");
        for (int i = 1; i < 300; i++) step(2'b11, 3'b001, 1'b1, 2'b00, 1, "R7");
        step(2'b00, 3'b000, 1'b1, 2'b00, 0, "R1");
        // random mix
        for (int i = 0; i < 6000; i++) begin
            int r;
            logic [1:0] tr;
            r = $urandom_range(0, 9);
            tr = (r < 6) ? 2'b11 : (r < 8) ? 2'b10 : (r < 9) ? 2'b01 : 2'b00;
            step(tr, 3'($urandom_range(0, 7)), ($urandom_range(0, 3) != 0),
                 2'($urandom_range(0, 3)), $urandom_range(0, 6), "R6");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule